// File: doc/BRIEF.md
# Reloading Down-Counter Pulse Generator

This block is one timer channel that produces a continuous square-wave style output. Software loads a 16-bit counter and a 16-bit reload value through a small write port, then starts the channel either by setting an enable bit or by pulsing an external start input. While it runs, a count-clock strobe steps the counter down by one. When the counter steps past zero the channel reloads, inverts its output flip-flop, and raises one-cycle interrupt and DMA request pulses.

The output also inverts once when counting begins, on the first count tick after the enable. That tick loads nothing and decrements nothing. As a result, the first interval between inversions is the initial counter value plus one ticks, and every later interval is the reload value plus one ticks. Only software can stop the channel. When stopped, the counter and the output level freeze, and the live counter value can be read at any time.

Top module: `pgen_channel`

## Requirements
- R1: A synchronous active-high reset sets the counter, the reload value, the enable bit and the output to zero, and holds the interrupt and DMA requests low.
- R2: A write with `wr_sel` = 2'b00 loads the counter and a write with `wr_sel` = 2'b01 loads the reload value. A write with `wr_sel` = 2'b10 sets the enable bit from `wr_data[0]`. A write with `wr_sel` = 2'b11 changes no state.
- R3: Counting starts when the enable goes from 0 to 1, either through a control write or through `ext_start`. On the first tick after that, the output inverts and the counter keeps its value.
- R4: While the channel is running, each tick lowers the counter by one. Cycles without a tick leave it unchanged.
- R5: A tick taken at counter value 0 is an underflow. After that edge the counter reads 16'hFFFF, the output has inverted, and `irq_o` and `dma_o` are both high for that one cycle.
- R6: The tick after an underflow loads reload minus one. If the reload value is 0, that tick is itself another underflow. Inversions after the first underflow are therefore spaced reload plus one ticks apart.
- R7: A control write that clears the enable bit, landing in the same cycle as `ext_start`, leaves the channel stopped.
- R8: While the channel is stopped, the counter and the output hold. A later re-enable inverts the output again at its first tick.
- R9: A counter write takes effect in the next cycle. It wins over a tick in the same cycle and cancels a pending reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 counter, 01 reload, 10 control, 11 none |
| wr_data | input | 16 | Write data; bit 0 is the enable bit for control writes |
| tick | input | 1 | Count-clock enable strobe |
| ext_start | input | 1 | External start request |
| cnt_o | output | 16 | Live counter value |
| pulse_o | output | 1 | Output flip-flop level |
| irq_o | output | 1 | Interrupt request pulse |
| dma_o | output | 1 | DMA request pulse |

## Verification
Some behaviour is checked by assertions on every cycle:
- the output inverts exactly on a start event or an underflow;
- the counter reads all ones after an underflow and takes reload minus one on the next tick;
- a stopped channel freezes both the counter and the output;
- a clearing control write always leaves the enable low;
- the two request lines always match.

Other behaviour can only be shown by the bench's scenarios:
- the arithmetic spacing of inversions over whole sequences, across a sweep of initial and reload values with and without idle cycles between ticks;
- write-over-tick priority while a reload is pending;
- restarting after a stop.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

    localparam int PGEN_SEL_W = 2;

    typedef enum logic [PGEN_SEL_W-1:0] {
        SEL_CNT  = 2'b00,
        SEL_RLD  = 2'b01,
        SEL_CTL  = 2'b10,
        SEL_NONE = 2'b11
    } pgen_sel_e;

endpackage

// File: rtl/pgen_enable.sv
module pgen_enable (
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr,
    input  logic ctl_bit,
    input  logic ext_start,
    input  logic tick,
    output logic en_o,
    output logic arm_o,
    output logic start_o
);

    typedef struct packed {
        logic en;
        logic arm;
    } en_st_t;

    en_st_t st_d, st_q;
    logic   start_d;

    always_comb begin
        st_d    = st_q;
        start_d = st_q.en & st_q.arm & tick;
        if (ctl_wr) begin
            st_d.en = ctl_bit;
        end else if (ext_start) begin
            st_d.en = 1'b1;
        end
        if (!st_d.en) begin
            st_d.arm = 1'b0;
        end else if (!st_q.en) begin
            st_d.arm = 1'b1;
        end else if (start_d) begin
            st_d.arm = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o    = st_q.en;
    assign arm_o   = st_q.arm;
    assign start_o = start_d;

    assert_disable_wins_R7: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && !ctl_bit |=> !en_o);

    assert_rise_arms_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(en_o) |-> arm_o);

endmodule

// File: rtl/pgen_count.sv
module pgen_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cnt,
    input  logic             wr_rld,
    input  logic [CNT_W-1:0] wdata,
    input  logic             tick,
    input  logic             run,
    output logic [CNT_W-1:0] cnt_o,
    output logic             uf_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             pend;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    step;
    logic    uf;

    always_comb begin
        step = run & tick;
        uf   = step & ((!st_q.pend && st_q.cnt == '0) ||
                       (st_q.pend && st_q.rld == '0));
        st_d = st_q;
        if (wr_rld) begin
            st_d.rld = wdata;
        end
        if (wr_cnt) begin
            st_d.cnt  = wdata;
            st_d.pend = 1'b0;
        end else if (uf) begin
            st_d.cnt  = '1;
            st_d.pend = 1'b1;
        end else if (step && st_q.pend) begin
            st_d.cnt  = st_q.rld - ONE;
            st_d.pend = 1'b0;
        end else if (step) begin
            st_d.cnt  = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign uf_o  = uf;

    assert_uf_all_ones_R5: assert property (@(posedge clk) disable iff (rst)
        uf_o && !wr_cnt |=> cnt_o == '1);

    assert_reload_minus_one_R6: assert property (@(posedge clk) disable iff (rst)
        run && tick && st_q.pend && st_q.rld != '0 && !wr_cnt
        |=> cnt_o == $past(st_q.rld - ONE));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(run && tick) && !wr_cnt |=> $stable(cnt_o));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> cnt_o == $past(wdata));

endmodule

// File: rtl/pgen_outff.sv
module pgen_outff (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic uf,
    output logic pulse_o,
    output logic irq_o,
    output logic dma_o
);

    typedef struct packed {
        logic lvl;
        logic irq;
        logic dma;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = st_q.lvl ^ (start | uf);
        st_d.irq = uf;
        st_d.dma = uf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.lvl;
    assign irq_o   = st_q.irq;
    assign dma_o   = st_q.dma;

    assert_toggle_on_event_R3: assert property (@(posedge clk) disable iff (rst)
        (start || uf) |=> pulse_o != $past(pulse_o));

    assert_hold_no_event_R8: assert property (@(posedge clk) disable iff (rst)
        !(start || uf) |=> $stable(pulse_o));

    assert_req_match_R5: assert property (@(posedge clk) disable iff (rst)
        irq_o == dma_o);

endmodule

// File: rtl/pgen_channel.sv
module pgen_channel
    import pgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [PGEN_SEL_W-1:0] wr_sel,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic                  tick,
    input  logic                  ext_start,
    output logic [CNT_W-1:0]      cnt_o,
    output logic                  pulse_o,
    output logic                  irq_o,
    output logic                  dma_o
);

    logic wr_cnt, wr_rld, wr_ctl;
    logic en, arm, start, run, uf;

    always_comb begin
        wr_cnt = wr_en && (wr_sel == SEL_CNT);
        wr_rld = wr_en && (wr_sel == SEL_RLD);
        wr_ctl = wr_en && (wr_sel == SEL_CTL);
        run    = en & ~arm;
    end

    pgen_enable u_enable (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (wr_ctl),
        .ctl_bit   (wr_data[0]),
        .ext_start (ext_start),
        .tick      (tick),
        .en_o      (en),
        .arm_o     (arm),
        .start_o   (start)
    );

    pgen_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .wr_cnt (wr_cnt),
        .wr_rld (wr_rld),
        .wdata  (wr_data),
        .tick   (tick),
        .run    (run),
        .cnt_o  (cnt_o),
        .uf_o   (uf)
    );

    pgen_outff u_outff (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .uf      (uf),
        .pulse_o (pulse_o),
        .irq_o   (irq_o),
        .dma_o   (dma_o)
    );

    assert_stopped_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        !en && !wr_cnt |=> $stable(cnt_o) && $stable(pulse_o));

    assert_no_uf_when_stopped_R8: assert property (@(posedge clk) disable iff (rst)
        !en |-> !uf && !start);

endmodule

// File: tb/pgen_channel_tb_top.sv
module pgen_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b00;
    logic [15:0] wr_data = '0;
    logic        tick = 1'b0;
    logic        ext_start = 1'b0;
    logic [15:0] cnt_o;
    logic        pulse_o, irq_o, dma_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pgen_channel dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tick(tick), .ext_start(ext_start), .cnt_o(cnt_o), .pulse_o(pulse_o),
        .irq_o(irq_o), .dma_o(dma_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic tk();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 cnt", cnt_o, 0);
        chk("R1 pulse", pulse_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 dma", dma_o, 0);
        tk();
        chk("R1 enable clear", {cnt_o, pulse_o}, 0);

        // R2: unused select is ignored
        wr(2'b00, 16'h0005);
        chk("R2 cnt write", cnt_o, 5);
        wr(2'b11, 16'h1234);
        tk();
        chk("R2 sel 11 ignored cnt", cnt_o, 5);
        chk("R2 sel 11 ignored pulse", pulse_o, 0);

        // R3 R4 R5 R6: sweep of initial and reload values
        for (int n = 0; n < 6; n++) begin
            for (int r = 0; r < 5; r++) begin
                for (int gap = 0; gap < 2; gap++) begin
                    logic ep;
                    int kmax;
                    do_reset();
                    wr(2'b00, 16'(n));
                    wr(2'b01, 16'(r));
                    wr(2'b10, 16'h0001);
                    ep = 1'b0;
                    kmax = 1 + (n + 1) + 3 * (r + 1);
                    for (int k = 1; k <= kmax; k++) begin
                        logic [15:0] ec;
                        logic tg;
                        int p, q;
                        if (gap != 0) begin
                            logic [15:0] prev;
                            prev = cnt_o;
                            @(negedge clk);
                            chk("R4 hold without tick", cnt_o, prev);
                        end
                        tk();
                        p = k - 1;
                        q = p - (n + 1);
                        if (k == 1) begin
                            tg = 1'b1; ec = 16'(n);
                        end else if (p <= n) begin
                            tg = 1'b0; ec = 16'(n - p);
                        end else if (q % (r + 1) == 0) begin
                            tg = 1'b1; ec = 16'hFFFF;
                        end else begin
                            tg = 1'b0; ec = 16'(r - (q % (r + 1)));
                        end
                        ep = ep ^ tg;
                        chk("R4 R6 counter value", cnt_o, ec);
                        chk("R3 R6 output level", pulse_o, ep);
                        chk("R5 irq pulse", irq_o, tg && k > 1);
                        chk("R5 dma pulse", dma_o, tg && k > 1);
                    end
                end
            end
        end

        // R7: disable write wins over external start
        do_reset();
        wr(2'b00, 16'd3);
        wr(2'b01, 16'd4);
        wr_en = 1'b1; wr_sel = 2'b10; wr_data = 16'h0000; ext_start = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ext_start = 1'b0;
        repeat (3) tk();
        chk("R7 stays stopped pulse", pulse_o, 0);
        chk("R7 stays stopped cnt", cnt_o, 3);

        // R3: external start
        ext_start = 1'b1;
        @(negedge clk);
        ext_start = 1'b0;
        tk();
        chk("R3 ext start toggles", pulse_o, 1);
        chk("R3 start tick keeps cnt", cnt_o, 3);
        tk();
        chk("R4 decrement", cnt_o, 2);

        // R8: stop holds, restart toggles
        wr(2'b10, 16'h0000);
        repeat (2) tk();
        chk("R8 hold cnt", cnt_o, 2);
        chk("R8 hold pulse", pulse_o, 1);
        wr(2'b10, 16'h0001);
        tk();
        chk("R8 restart toggles", pulse_o, 0);
        chk("R8 restart keeps cnt", cnt_o, 2);
        tk();
        chk("R8 resumes", cnt_o, 1);

        // R9: write beats tick, cancels pending reload
        wr_en = 1'b1; wr_sel = 2'b00; wr_data = 16'd9; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        chk("R9 write over tick", cnt_o, 9);
        tk();
        chk("R9 counts from written", cnt_o, 8);
        wr(2'b00, 16'd0);
        tk();
        chk("R5 underflow value", cnt_o, 16'hFFFF);
        chk("R5 underflow irq", irq_o, 1);
        wr(2'b00, 16'd3);
        chk("R9 write during pending", cnt_o, 3);
        tk();
        chk("R9 pending cancelled", cnt_o, 2);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule